// File: doc/BRIEF.md
# Byte-Command Serial Shift Engine

This block reads a stream of command bytes and turns them into activity on a three-wire synchronous serial port (clock, data out, data in) and on two 8-bit general-purpose pin banks. Each command begins with one opcode byte, and parameter bytes may follow it. A shift-transfer opcode has flag bits that choose whether the transfer is counted in bytes or in bits, whether data is driven out, whether data is captured, which end of each byte goes first, and which clock edge launches and which edge samples. Other opcodes write or read a pin bank, or produce clock pulses that carry no data.

The serial clock idles low. It advances one half-period for each cycle in which the external `tick` strobe is high, so the host logic sets the bit rate. Every byte captured from the serial line is returned on a valid/ready output stream. Pin-bank reads and error replies use the same output stream. A host normally sends a pin-bank write to set chip-select, then a shift transfer, and then reads back the captured bytes.

Top module: `byte_shift_engine`

## Requirements
- R1: After reset, `sck` is low, `sdo` is low, `busy` and `out_valid` are low, `in_ready` is high, and both pin banks have value and direction 0x00.
- R2: An opcode with bit 7 and bit 6 clear is a shift transfer. Its flags are: bit 5 = capture input, bit 4 = drive output, bit 3 = LSB first (MSB first when clear), bit 2 = sample on the falling edge, bit 1 = count bits, bit 0 = launch on the falling edge.
- R3: A byte-counted transfer takes a length low byte and then a length high byte holding N-1. It gives exactly 8*N clock pulses. It takes N payload bytes, one before each byte is shifted, and only when the drive-output flag is set.
- R4: A bit-counted transfer takes one length byte, and the low 3 bits of that byte hold N-1, so it gives N = 1 to 8 pulses. When output is enabled it takes one payload byte. When input is enabled it returns exactly one byte.
- R5: With launch-on-falling set, the first bit is on `sdo` before the first rising edge and later bits change only on falling edges. With it clear, each bit is put out at a rising edge.
- R6: `sdi` is sampled on the rising edge, or on the falling edge when the sample-on-falling flag is set.
- R7: MSB first sends payload bit 7 first and shifts received bits in from bit 0 upward, so after N bits the received bits sit in bits N-1..0. LSB first sends bit 0 first and shifts received bits in from bit 7 downward. Unfilled bits read as 0.
- R8: With the capture flag set, one byte is returned for each byte shifted. With it clear, the transfer returns nothing.
- R9: Opcode 0x80 (low bank) or 0x82 (high bank) is followed by a value byte and then a direction byte, and the bank outputs take both.
- R10: Opcode 0x81 returns the low-bank pin levels as one byte, and 0x83 returns the high-bank pin levels.
- R11: Opcode 0x8E with one byte (low 3 bits = N-1) gives N clock pulses. Opcode 0x8F with a 16-bit N-1 (low byte first) gives 8*N pulses. Neither takes payload, returns data or changes `sdo`.
- R12: Any other opcode, including one with bit 7 clear and bit 6 set, is answered with 0xFA and then the opcode. The engine then accepts a new command.
- R13: `sck` changes only in the cycle after one in which `tick` was high, and it is low whenever `busy` is low.
- R14: `busy` is high from the cycle after an opcode is accepted until the command finishes and its last reply byte is taken. `in_ready` is low while a byte is being shifted or offered. An offered byte holds steady until `out_ready`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| in_valid | input | 1 | Command byte valid |
| in_data | input | 8 | Command byte |
| in_ready | output | 1 | Command byte accepted when high with in_valid |
| out_valid | output | 1 | Reply byte valid |
| out_data | output | 8 | Reply byte |
| out_ready | input | 1 | Reply byte taken when high with out_valid |
| tick | input | 1 | Half-period enable strobe for the serial clock |
| sck | output | 1 | Serial clock, idles low |
| sdo | output | 1 | Serial data out |
| sdi | input | 1 | Serial data in |
| lo_val | output | 8 | Low pin bank output value |
| lo_dir | output | 8 | Low pin bank direction (1 = drive) |
| lo_pins | input | 8 | Low pin bank levels |
| hi_val | output | 8 | High pin bank output value |
| hi_dir | output | 8 | High pin bank direction (1 = drive) |
| hi_pins | input | 8 | High pin bank levels |
| busy | output | 1 | Command in progress |

## Verification
The hardest case to reach from the ports is the pairing of launch and sample edges. Bits moving on one clock edge must be observed on the other edge, and these bits are easy to mix up with the idle value left on `sdo`. The bench therefore has a serial partner that records `sdo` on the edge opposite launch and changes `sdi` on the edge opposite sampling. A table of single-byte transfers takes this partner through all eight combinations of bit order, launch edge and sample edge. Directed runs then cover partial bit counts in both bit orders, a 16-bit clock-only count that uses the high length byte, and a reply held back by `out_ready`.

// File: rtl/byte_shift_engine.sv
module byte_shift_engine (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       in_valid,
  input  logic [7:0] in_data,
  output logic       in_ready,
  output logic       out_valid,
  output logic [7:0] out_data,
  input  logic       out_ready,
  input  logic       tick,
  output logic       sck,
  output logic       sdo,
  input  logic       sdi,
  output logic [7:0] lo_val,
  output logic [7:0] lo_dir,
  input  logic [7:0] lo_pins,
  output logic [7:0] hi_val,
  output logic [7:0] hi_dir,
  input  logic [7:0] hi_pins,
  output logic       busy
);
  localparam logic [7:0] ERR_CODE = 8'hFA;

  typedef enum logic [3:0] {
    S_CMD, S_LEN0, S_LEN1, S_ARG, S_ARG2, S_DATA, S_SHIFT, S_RESP, S_ERR
  } state_t;

  state_t st;
  logic [7:0]  len_lo, txr, rxr, resp;
  logic [15:0] bytes_left;
  logic [3:0]  bits_left;
  logic        more;
  logic        f_in, f_out, f_lsb, f_icn, f_bits, f_ocn, f_hi;

  wire take = in_valid && in_ready;
  wire give = out_valid && out_ready;

  assign in_ready  = st inside {S_CMD, S_LEN0, S_LEN1, S_ARG, S_ARG2, S_DATA};
  assign out_valid = (st == S_RESP) || (st == S_ERR);
  assign out_data  = (st == S_ERR) ? ERR_CODE : resp;
  assign busy      = (st != S_CMD);

  wire       nb       = f_lsb ? txr[0] : txr[7];
  wire [7:0] tx_sh    = f_lsb ? {1'b0, txr[7:1]} : {txr[6:0], 1'b0};
  wire [7:0] rx_sh    = f_lsb ? {sdi, rxr[7:1]} : {rxr[6:0], sdi};
  wire       last_bit = (bits_left == 4'd1);
  wire       has_more = (bytes_left != 16'd0);
  state_t    first;
  assign first = f_out ? S_DATA : S_SHIFT;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      st <= S_CMD;
      len_lo <= '0; txr <= '0; rxr <= '0; resp <= '0;
      bytes_left <= '0; bits_left <= '0; more <= 1'b0;
      {f_in, f_out, f_lsb, f_icn, f_bits, f_ocn, f_hi} <= '0;
      sck <= 1'b0; sdo <= 1'b0;
      lo_val <= '0; lo_dir <= '0; hi_val <= '0; hi_dir <= '0;
    end else begin
      case (st)
        S_CMD: if (take) begin
          rxr <= '0;
          {f_in, f_out, f_lsb, f_icn, f_bits, f_ocn} <=
            in_data[7] ? {4'b0, in_data == 8'h8E, 1'b0} : in_data[5:0];
          if (!in_data[7] && !in_data[6]) st <= S_LEN0;
          else begin
            case (in_data)
              8'h80, 8'h82: begin f_hi <= in_data[1]; st <= S_ARG; end
              8'h81: begin resp <= lo_pins; more <= 1'b0; st <= S_RESP; end
              8'h83: begin resp <= hi_pins; more <= 1'b0; st <= S_RESP; end
              8'h8E, 8'h8F: st <= S_LEN0;
              default: begin resp <= in_data; more <= 1'b0; st <= S_ERR; end
            endcase
          end
        end
        S_LEN0: if (take) begin
          len_lo <= in_data;
          if (f_bits) begin
            bits_left  <= {1'b0, in_data[2:0]} + 4'd1;
            bytes_left <= '0;
            st <= first;
          end else st <= S_LEN1;
        end
        S_LEN1: if (take) begin
          bytes_left <= {in_data, len_lo};
          bits_left  <= 4'd8;
          st <= first;
        end
        S_ARG: if (take) begin
          if (f_hi) hi_val <= in_data; else lo_val <= in_data;
          st <= S_ARG2;
        end
        S_ARG2: if (take) begin
          if (f_hi) hi_dir <= in_data; else lo_dir <= in_data;
          st <= S_CMD;
        end
        S_DATA: if (take) begin
          if (f_ocn) begin
            sdo <= f_lsb ? in_data[0] : in_data[7];
            txr <= f_lsb ? {1'b0, in_data[7:1]} : {in_data[6:0], 1'b0};
          end else txr <= in_data;
          st <= S_SHIFT;
        end
        S_SHIFT: if (tick) begin
          if (!sck) begin
            sck <= 1'b1;
            if (f_out && !f_ocn) begin sdo <= nb; txr <= tx_sh; end
            if (f_in && !f_icn) rxr <= rx_sh;
          end else begin
            sck <= 1'b0;
            bits_left <= bits_left - 4'd1;
            if (f_in && f_icn) rxr <= rx_sh;
            if (last_bit) begin
              resp <= (f_in && f_icn) ? rx_sh : rxr;
              rxr <= '0;
              bits_left <= 4'd8;
              more <= has_more;
              if (has_more) bytes_left <= bytes_left - 16'd1;
              st <= f_in ? S_RESP : (has_more ? first : S_CMD);
            end else if (f_out && f_ocn) begin
              sdo <= nb; txr <= tx_sh;
            end
          end
        end
        S_RESP: if (give) st <= more ? first : S_CMD;
        S_ERR:  if (give) st <= S_RESP;
        default: st <= S_CMD;
      endcase
    end
  end
endmodule

module byte_shift_engine_chk (
  input logic       clk,
  input logic       rst_n,
  input logic       in_valid,
  input logic       in_ready,
  input logic       out_valid,
  input logic [7:0] out_data,
  input logic       out_ready,
  input logic       tick,
  input logic       sck,
  input logic       sdo,
  input logic       busy
);
  AST_SCK_IDLE_LOW: assert property (@(posedge clk) disable iff (!rst_n)
    !busy |-> !sck); // R13
  AST_SCK_NEEDS_TICK: assert property (@(posedge clk) disable iff (!rst_n)
    !tick |=> $stable(sck)); // R13
  AST_REPLY_HELD: assert property (@(posedge clk) disable iff (!rst_n)
    (out_valid && !out_ready) |=> (out_valid && $stable(out_data))); // R14
  AST_NO_INPUT_WHILE_REPLY: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid |-> !in_ready); // R14
  AST_SDO_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
    (!tick && !(in_valid && in_ready)) |=> $stable(sdo)); // R5
endmodule

bind byte_shift_engine byte_shift_engine_chk u_chk (.*);

// File: tb/byte_shift_engine_test.sv
`timescale 1ns/1ps
module byte_shift_engine_test;
  logic clk = 0, rst_n = 0;
  logic in_valid = 0, out_ready = 0, tick = 0;
  logic [7:0] in_data = 0, lo_pins = 8'h3C, hi_pins = 8'hC5;
  logic in_ready, out_valid, sck, sdo, busy, sdi_tb;
  logic [7:0] out_data, lo_val, lo_dir, hi_val, hi_dir;
  int tests = 0, fails = 0;

  byte_shift_engine uut (
    .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_data(in_data), .in_ready(in_ready),
    .out_valid(out_valid), .out_data(out_data), .out_ready(out_ready), .tick(tick),
    .sck(sck), .sdo(sdo), .sdi(sdi_tb), .lo_val(lo_val), .lo_dir(lo_dir), .lo_pins(lo_pins),
    .hi_val(hi_val), .hi_dir(hi_dir), .hi_pins(hi_pins), .busy(busy));

  always #2.5 clk = ~clk;
  always @(negedge clk) tick <= ~tick;

  // serial partner: logs sdo on the non-launch edge, moves sdi on the non-sample edge
  logic s_icn = 0, s_ocn = 0;
  logic [31:0] pat = 0, txlog = 0;
  int ptr = 0, nrise = 0;
  always @(sck) begin
    if (sck) begin
      nrise++;
      if (s_ocn) txlog = {txlog[30:0], sdo};
      if (s_icn) ptr++;
    end else begin
      if (!s_ocn) txlog = {txlog[30:0], sdo};
      if (!s_icn) ptr++;
    end
  end
  always_comb begin
    int idx;
    idx = s_icn ? ptr - 1 : ptr;
    sdi_tb = (idx < 0 || idx > 31) ? 1'b0 : pat[31 - idx];
  end

  task automatic arm(input logic icn, input logic ocn, input logic [31:0] p);
    s_icn = icn; s_ocn = ocn; pat = p; ptr = 0; nrise = 0; txlog = 0;
  endtask

  task automatic chk(input logic ok, input string req, input int act, input int exp);
    tests++;
    if (!ok) begin
      fails++;
      $display("FAIL %s: actual 0x%0h expected 0x%0h", req, act, exp);
    end
  endtask

  task automatic put(input logic [7:0] b);
    in_data = b; in_valid = 1;
    while (!in_ready) @(negedge clk);
    @(negedge clk);
    in_valid = 0;
  endtask

  task automatic get(output logic [7:0] b);
    out_ready = 1;
    while (!out_valid) @(negedge clk);
    b = out_data;
    @(negedge clk);
    out_ready = 0;
  endtask

  task automatic wait_idle();
    while (busy) @(negedge clk);
  endtask

  // {opcode, payload, partner byte, expected reply, expected sdo bits}; R2 R5 R6 R7
  localparam logic [39:0] VEC [8] = '{
    40'h30_A5_3C_3C_A5, 40'h31_5A_C3_C3_5A, 40'h34_81_96_96_81, 40'h35_7E_0F_0F_7E,
    40'h38_01_80_01_80, 40'h39_12_35_AC_48, 40'h3C_F0_06_60_0F, 40'h3D_C8_E1_87_13};

  initial begin
    repeat (200000) @(posedge clk);
    tests++; fails++;
    $display("FAIL watchdog: actual 1 expected 0");
    $display("[TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end

  initial begin
    logic [7:0] b, s0;
    repeat (4) @(negedge clk);
    rst_n = 1;
    @(negedge clk);
    chk(!sck && !sdo && !busy && !out_valid && in_ready, "R1 idle", {sck, sdo, busy, out_valid, in_ready}, 1);
    chk(lo_val == 0 && lo_dir == 0 && hi_val == 0 && hi_dir == 0, "R1 banks", {lo_val, lo_dir, hi_val, hi_dir}, 0);

    for (int i = 0; i < 8; i++) begin
      logic [39:0] v;
      v = VEC[i];
      arm(v[34], v[32], {v[23:16], 24'h0});
      put(v[39:32]); put(8'h00); put(8'h00); put(v[31:24]);
      get(b);
      chk(b == v[15:8], "R6 R7 reply", b, v[15:8]);
      wait_idle();
      chk(txlog[7:0] == v[7:0], "R5 R7 sdo bits", txlog[7:0], v[7:0]);
    end

    // two-byte output-only transfer
    arm(0, 1, 0);
    put(8'h11); put(8'h01); put(8'h00); put(8'hDE); put(8'hAD);
    @(negedge clk);
    chk(busy && !in_ready, "R14 shifting", {busy, in_ready}, 2);
    wait_idle();
    chk(txlog[15:0] == 16'hDEAD, "R3 payload", txlog[15:0], 16'hDEAD);
    chk(nrise == 16, "R3 pulses", nrise, 16);
    chk(!out_valid, "R8 no reply", out_valid, 0);

    // input-only: no payload
    arm(1, 0, 32'hB7000000);
    put(8'h24); put(8'h00); put(8'h00);
    get(b);
    chk(b == 8'hB7, "R3 R8 input only", b, 8'hB7);
    wait_idle();
    chk(nrise == 8, "R3 input pulses", nrise, 8);

    // bit mode MSB first, 3 bits
    arm(0, 1, 32'hC0000000);
    put(8'h33); put(8'h02); put(8'hA0);
    get(b);
    chk(b == 8'h06, "R4 R7 bit msb reply", b, 8'h06);
    wait_idle();
    chk(txlog[2:0] == 3'b101, "R4 bit msb sdo", txlog[2:0], 5);
    chk(nrise == 3, "R4 bit pulses", nrise, 3);

    // bit mode LSB first, 5 bits
    arm(0, 1, 32'h98000000);
    put(8'h3B); put(8'h04); put(8'h15);
    get(b);
    chk(b == 8'hC8, "R7 bit lsb reply", b, 8'hC8);
    wait_idle();
    chk(txlog[4:0] == 5'h15, "R7 bit lsb sdo", txlog[4:0], 5'h15);

    // pin banks
    put(8'h80);
    chk(busy, "R14 busy after opcode", busy, 1);
    put(8'h5A); put(8'hF0);
    @(negedge clk);
    chk(lo_val == 8'h5A && lo_dir == 8'hF0 && hi_val == 0 && !busy, "R9 low bank", {lo_val, lo_dir}, 16'h5AF0);
    put(8'h82); put(8'hA5); put(8'h0F);
    @(negedge clk);
    chk(hi_val == 8'hA5 && hi_dir == 8'h0F && lo_val == 8'h5A, "R9 high bank", {hi_val, hi_dir}, 16'hA50F);
    put(8'h81); get(b);
    chk(b == 8'h3C, "R10 low read", b, 8'h3C);
    put(8'h83); get(b);
    chk(b == 8'hC5, "R10 high read", b, 8'hC5);

    // clock-only commands
    arm(0, 0, 0);
    s0 = sdo;
    put(8'h8E); put(8'h04);
    wait_idle();
    chk(nrise == 5, "R11 bit pulses", nrise, 5);
    chk(sdo == s0 && !out_valid, "R11 sdo kept", sdo, s0);
    arm(0, 0, 0);
    put(8'h8F); put(8'h02); put(8'h01);
    wait_idle();
    chk(nrise == 2072, "R11 R3 byte pulses", nrise, 2072);
    chk(sdo == s0, "R11 sdo kept 2", sdo, s0);

    // unknown opcodes, with reply held back
    put(8'h8B);
    repeat (5) @(negedge clk);
    chk(out_valid && out_data == 8'hFA && !in_ready, "R14 held reply", out_data, 8'hFA);
    get(b);
    chk(b == 8'hFA, "R12 code", b, 8'hFA);
    get(b);
    chk(b == 8'h8B, "R12 echo", b, 8'h8B);
    put(8'h40); get(b);
    chk(b == 8'hFA, "R12 bit6 code", b, 8'hFA);
    get(b);
    chk(b == 8'h40, "R12 bit6 echo", b, 8'h40);
    put(8'h81); get(b);
    chk(b == 8'h3C, "R12 recovers", b, 8'h3C);
    @(negedge clk);
    chk(!busy && !sck, "R13 R14 idle end", {busy, sck}, 0);

    $display("[TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end
endmodule